// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds off for a start-up delay given in microseconds. It then runs a burst of initialization refresh cycles. After that it issues refresh cycles at an even pace, so that every row is refreshed within the retention period. Before each cycle it raises a bus request to the access controller and waits for a grant. While it holds the bus, it drives the row strobe, the column strobe and the write enable itself.

Two refresh styles are supported, chosen by a mode input. The default style lowers the column strobe before the row strobe and lets the memory's own row counter pick the row. The alternative style keeps the column strobe high and drives an explicit row address from a local counter. Because the internal-counter style covers two rows per cycle, the pace in the explicit-row style is twice as fast. Refresh events that fall due while the grant is withheld are counted up to a limit. Once the grant returns they are issued back to back. A ready output stays low until initialization is over, and the access controller holds off host traffic while it is low.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are 1, and bus_req, init_done and addr_oe are 0.
- R2: The first bus request comes no earlier than STARTUP_US microseconds of clock cycles after reset is released, and no more than three cycles later.
- R3: Exactly INIT_CYCLES refresh cycles (row-strobe falling edges) happen before init_done rises. Once init_done is 1 it stays 1 until reset.
- R4: ras_n and cas_n go low only while bus_req is 1. While bus_grant is 0, no refresh cycle starts and bus_req stays 1 once raised.
- R5: When ras_only_mode is 0, cas_n is 0 in the cycle before ras_n falls and in the first cycle ras_n is low. we_n is 1 whenever ras_n falls.
- R6: ras_n stays low for at least ceil(T_RAS_NS) clock cycles per refresh (3 at 50 MHz with defaults). It stays high for at least ceil(T_RP_NS) cycles between refreshes.
- R7: When ras_only_mode is 1, cas_n stays 1 and addr_oe is 1 for at least one cycle before ras_n falls. row_addr is stable while ras_n is low.
- R8: The row counter starts at 0. It steps by one after each explicit-row refresh and wraps from 2^ROW_BITS-1 to 0. Internal-counter refreshes leave it unchanged.
- R9: After initialization, refreshes are spaced by floor(retention cycles / 2^(ROW_BITS-1)) cycles when ras_only_mode is 0, and by floor(retention cycles / 2^ROW_BITS) cycles when it is 1. No refresh happens that was not due.
- R10: Refreshes that fall due while the grant is withheld are queued up to MAX_PENDING and issued back to back once the grant returns. Further due events are dropped.
- R11: bus_req returns to 0 after a refresh cycle's precharge once nothing is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_mode | input | 1 | 1: explicit-row refresh; 0: CAS-before-RAS refresh; sampled at each grant |
| bus_grant | input | 1 | Access controller hands the DRAM pins to this block |
| bus_req | output | 1 | Request for the DRAM pins, held through the whole refresh cycle |
| init_done | output | 1 | Initialization refresh burst finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr_oe | output | 1 | Drive row_addr onto the DRAM address pins |
| row_addr | output | ROW_BITS | Row to refresh in explicit-row mode |

## Verification
Every cycle, the bound checker enforces the strobe ordering relative to ownership of the bus. It also enforces the CAS-before-RAS lead and hold, the minimum low and high widths of the row strobe, the address setup and stability in explicit-row mode, the single-step row counter and the sticky ready flag. The bench scenarios cover what no per-cycle property can see. These are the start-up delay, the exact count of initialization cycles and the spacing of refreshes in each mode. They also cover the backlog being capped and drained after a withheld grant, and the row counter wrapping after sixteen refreshes with a reduced row width.

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int STARTUP_US   = 200,
  parameter int RETENTION_US = 64_000,
  parameter int ROW_BITS     = 13,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PENDING  = 4,
  parameter int T_RAS_NS     = 60,
  parameter int T_RP_NS      = 40,
  parameter int T_CSR_NS     = 10,
  parameter int T_CHR_NS     = 10,
  parameter int T_RAH_NS     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only_mode,
  input  logic                bus_grant,
  output logic                bus_req,
  output logic                init_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                addr_oe,
  output logic [ROW_BITS-1:0] row_addr
);

  function automatic int ns_to_cyc(input int ns);
    longint p;
    p = (longint'(ns) * longint'(CLK_HZ) + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (p < 1) ? 1 : int'(p);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam longint STARTUP_CYC = longint'(STARTUP_US) * longint'(CLK_HZ) / 1_000_000;
  localparam longint RET_CYC     = longint'(RETENTION_US) * longint'(CLK_HZ) / 1_000_000;
  localparam int IVL_RO  = int'(RET_CYC >>> ROW_BITS);
  localparam int IVL_CBR = int'(RET_CYC >>> (ROW_BITS - 1));
  localparam int CSR_CYC = ns_to_cyc(T_CSR_NS);
  localparam int CHR_CYC = ns_to_cyc(T_CHR_NS);
  localparam int LOW_CYC = imax(ns_to_cyc(T_RAS_NS), imax(CHR_CYC + 1, ns_to_cyc(T_RAH_NS)));
  localparam int RP_CYC  = ns_to_cyc(T_RP_NS);
  localparam int PH_W = $clog2(imax(imax(CSR_CYC, LOW_CYC), RP_CYC) + 1);
  localparam int ST_W = $clog2(int'(STARTUP_CYC) + 1);
  localparam int IV_W = $clog2(IVL_CBR + 1);
  localparam int PD_W = $clog2(MAX_PENDING + 1);
  localparam int IN_W = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_REQ, S_SET, S_LOW, S_PRE} state_t;

  state_t                st;
  logic [PH_W-1:0]       ph;
  logic [PH_W-1:0]       ph_lim;
  logic [ST_W-1:0]       boot;
  logic [IV_W-1:0]       ivl;
  logic [IV_W-1:0]       ivl_lim;
  logic [PD_W-1:0]       pend;
  logic [IN_W-1:0]       init_left;
  logic [ROW_BITS-1:0]   row;
  logic                  ro_q;
  logic                  ph_end, done, tick, owe, take;

  always_comb begin
    case (st)
      S_SET:   ph_lim = PH_W'(CSR_CYC - 1);
      S_LOW:   ph_lim = PH_W'(LOW_CYC - 1);
      default: ph_lim = PH_W'(RP_CYC - 1);
    endcase
  end

  assign ph_end  = (ph == ph_lim);
  assign done    = (st == S_PRE) && ph_end;
  assign ivl_lim = ras_only_mode ? IV_W'(IVL_RO - 1) : IV_W'(IVL_CBR - 1);
  assign tick    = init_done && (ivl >= ivl_lim);
  assign owe     = !init_done || (pend != '0);
  assign take    = done && init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PWR;
      ph   <= '0;
      boot <= '0;
      ro_q <= 1'b0;
    end else begin
      case (st)
        S_PWR:
          if (boot == ST_W'(STARTUP_CYC - 1)) st <= S_IDLE;
          else boot <= boot + 1'b1;
        S_IDLE:
          if (owe) st <= S_REQ;
        S_REQ:
          if (bus_grant) begin
            st   <= S_SET;
            ph   <= '0;
            ro_q <= ras_only_mode;
          end
        default:
          if (ph_end) begin
            ph <= '0;
            case (st)
              S_SET:   st <= S_LOW;
              S_LOW:   st <= S_PRE;
              default: st <= S_IDLE;
            endcase
          end else begin
            ph <= ph + 1'b1;
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_left <= IN_W'(INIT_CYCLES);
      init_done <= 1'b0;
    end else if (done && !init_done) begin
      init_left <= init_left - 1'b1;
      if (init_left == IN_W'(1)) init_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ivl <= '0;
    else if (!init_done || tick) ivl <= '0;
    else                        ivl <= ivl + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= '0;
    else if (tick && !take && pend != PD_W'(MAX_PENDING))
      pend <= pend + 1'b1;
    else if (!tick && take)
      pend <= pend - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            row <= '0;
    else if (done && ro_q) row <= row + 1'b1;
  end

  assign bus_req  = (st == S_REQ) || (st == S_SET) || (st == S_LOW) || (st == S_PRE);
  assign ras_n    = (st != S_LOW);
  assign cas_n    = !(!ro_q && ((st == S_SET) || ((st == S_LOW) && (ph < PH_W'(CHR_CYC)))));
  assign we_n     = 1'b1;
  assign addr_oe  = ro_q && ((st == S_SET) || (st == S_LOW));
  assign row_addr = row;

endmodule

// File: rtl/dram_refresh_chk.sv
`timescale 1ns/1ps
module dram_refresh_chk #(
  parameter int ROW_BITS = 13,
  parameter int CLK_HZ   = 50_000_000,
  parameter int T_RAS_NS = 60,
  parameter int T_RP_NS  = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req,
  input logic                init_done,
  input logic                ras_n,
  input logic                cas_n,
  input logic                addr_oe,
  input logic [ROW_BITS-1:0] row_addr
);
  function automatic int ns_to_cyc(input int ns);
    longint p;
    p = (longint'(ns) * longint'(CLK_HZ) + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (p < 1) ? 1 : int'(p);
  endfunction

  localparam int RAS_MIN = ns_to_cyc(T_RAS_NS);
  localparam int RP_MIN  = ns_to_cyc(T_RP_NS);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'hFFFF;
    end else if (!ras_n) begin
      lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
      hi_cnt <= '0;
    end else begin
      hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= '0;
    end
  end

  p_strobe_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> bus_req);
  p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> $past(!cas_n));
  p_cas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> !cas_n);
  p_ras_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= 16'(RAS_MIN)));
  p_ras_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(RP_MIN)));
  p_ro_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> cas_n);
  p_ro_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && addr_oe) |-> $past(addr_oe));
  p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n) && addr_oe) |-> $stable(row_addr));
  p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |-> (row_addr == ROW_BITS'($past(row_addr) + 1'b1)));
  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .ROW_BITS(ROW_BITS), .CLK_HZ(CLK_HZ), .T_RAS_NS(T_RAS_NS), .T_RP_NS(T_RP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .init_done(init_done),
  .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
  localparam int RB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic gnt_en = 1'b1;
  logic bus_grant, bus_req, init_done, ras_n, cas_n, we_n, addr_oe;
  logic [RB-1:0] row_addr;

  assign bus_grant = bus_req & gnt_en;

  dram_refresh_seq #(
    .CLK_HZ(50_000_000), .STARTUP_US(2), .RETENTION_US(64),
    .ROW_BITS(RB), .INIT_CYCLES(8), .MAX_PENDING(3)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .bus_grant(bus_grant),
    .bus_req(bus_req), .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr_oe(addr_oe), .row_addr(row_addr)
  );

  always #10 clk = ~clk;

  typedef struct packed { logic ro; logic [RB-1:0] row; } ev_t;
  ev_t exp_q[$];
  ev_t e;

  int checks = 0, bad = 0, cyc = 0, fall_cnt = 0, first_req = -1;
  int lo_w = 0, last_rise = -100;
  int fall_at [0:63];
  logic [RB-1:0] row_at [0:63];
  logic p_ras = 1'b1, p_cas = 1'b1, p_oe = 1'b0, row_moved = 1'b0;
  logic [RB-1:0] fall_row = '0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_ev(input bit ro, input int row);
    ev_t x;
    x.ro = ro;
    x.row = RB'(row);
    exp_q.push_back(x);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (first_req < 0 && bus_req) first_req = cyc;
      if (!ras_n && p_ras) begin
        if (fall_cnt < 64) begin
          fall_at[fall_cnt] = cyc;
          row_at[fall_cnt] = row_addr;
        end
        check(cyc - last_rise >= 2, "R6 RAS high time", cyc - last_rise, 2);
        check(we_n == 1'b1, "R5 WE high at RAS fall", we_n, 1);
        if (addr_oe) begin
          check(p_oe == 1'b1, "R7 address driven before RAS falls", p_oe, 1);
          check(cas_n == 1'b1, "R7 CAS high in row-address refresh", cas_n, 1);
        end else begin
          check(p_cas == 1'b0, "R5 CAS low before RAS falls", p_cas, 0);
          check(cas_n == 1'b0, "R5 CAS held low after RAS falls", cas_n, 0);
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected refresh", fall_cnt, -1);
        end else begin
          e = exp_q.pop_front();
          check(e.ro == addr_oe, "R7 refresh kind", addr_oe, e.ro);
          if (e.ro) check(row_addr == e.row, "R8 row address", row_addr, e.row);
        end
        fall_row = row_addr;
        row_moved = 1'b0;
        fall_cnt++;
        lo_w = 0;
      end
      if (!ras_n) begin
        lo_w++;
        if (addr_oe && row_addr != fall_row) row_moved = 1'b1;
        if (addr_oe && cas_n == 1'b0) check(1'b0, "R7 CAS low during row-address refresh", 0, 1);
      end
      if (ras_n && !p_ras) begin
        check(lo_w == 3, "R6 RAS low width", lo_w, 3);
        check(!row_moved, "R7 row stable while RAS low", row_moved, 0);
        last_rise = cyc;
      end
      if (!ras_n || !cas_n) begin
        if (!bus_req) check(1'b0, "R4 strobe without request", bus_req, 1);
      end
      p_ras = ras_n;
      p_cas = cas_n;
      p_oe  = addr_oe;
      if (cyc > 20000) begin
        check(1'b0, "watchdog expired", cyc, 20000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ras_n, cas_n, we_n, bus_req, init_done, addr_oe} == 6'b111000,
          "R1 reset state", {ras_n, cas_n, we_n, bus_req, init_done, addr_oe}, 6'b111000);
    for (int i = 0; i < 8; i++) push_ev(1'b0, 0);
    rst_n = 1'b1;

    wait (fall_cnt >= 1);
    check(first_req >= 100 && first_req <= 103, "R2 start-up delay", first_req, 101);
    check(init_done == 1'b0, "R3 not ready during init", init_done, 0);

    wait (init_done);
    check(fall_cnt == 8, "R3 init refresh count", fall_cnt, 8);
    repeat (2) @(negedge clk);
    check(bus_req == 1'b0, "R11 bus released after init", bus_req, 0);

    for (int i = 0; i < 3; i++) push_ev(1'b0, 0);
    wait (fall_cnt >= 11);
    check(fall_at[10] - fall_at[9] == 400, "R9 CBR refresh spacing", fall_at[10] - fall_at[9], 400);
    check(fall_at[9] - fall_at[8] == 400, "R9 CBR refresh spacing", fall_at[9] - fall_at[8], 400);

    repeat (10) @(negedge clk);
    check(bus_req == 1'b0, "R11 bus released between refreshes", bus_req, 0);
    gnt_en = 1'b0;
    repeat (2090) @(negedge clk);
    check(fall_cnt == 11, "R4 no refresh without grant", fall_cnt, 11);
    check(bus_req == 1'b1, "R4 request held while waiting", bus_req, 1);
    for (int i = 0; i < 3; i++) push_ev(1'b0, 0);
    gnt_en = 1'b1;
    repeat (200) @(negedge clk);
    check(fall_cnt == 14, "R10 backlog capped and drained", fall_cnt, 14);
    check(fall_at[13] - fall_at[11] < 40, "R10 backlog issued back to back",
          fall_at[13] - fall_at[11], 16);
    check(bus_req == 1'b0, "R11 bus released after backlog", bus_req, 0);

    for (int i = 0; i < 18; i++) push_ev(1'b1, i % 16);
    mode = 1'b1;
    wait (fall_cnt >= 32);
    check(fall_at[31] - fall_at[30] == 200, "R9 row-address refresh spacing",
          fall_at[31] - fall_at[30], 200);
    check(row_at[29] == 4'd15, "R8 last row before wrap", row_at[29], 15);
    check(row_at[30] == 4'd0, "R8 row wraps to zero", row_at[30], 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 all expected refreshes seen", exp_q.size(), 0);
    check({bus_req, ras_n, cas_n, addr_oe} == 4'b0110, "R11 idle after refresh",
          {bus_req, ras_n, cas_n, addr_oe}, 4'b0110);
    summary();
  end
endmodule